// File: doc/BRIEF.md
# ATA PIO Cycle Sequencer

This block turns one host request into one complete programmed-I/O transfer on a parallel ATA device bus. A request names a task-file or control-block register (three address bits plus a control-block flag), says whether it reads or writes, says whether it targets the 16-bit data port or an 8-bit register, and carries the write word. The sequencer then drives the chip selects, the address lines, the read or write strobe and the data-bus enable. Read data is returned together with a one-cycle completion pulse.

All phase lengths are counted in system clock cycles and come from configuration inputs. The setup count is shared by both kinds of transfer. Register accesses use one set of active, cycle and recovery counts, and data-port accesses use a second set. A device may hold IORDY low to stretch the active phase, but only up to a fixed limit counted from strobe assertion. After a write, the data bus stays enabled for a few cycles that depend on the configured PIO mode.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, and whenever the block is idle with no write hold pending, both strobes and both chip selects are high, the data-bus enable is low and `req_ready` is high.
- R2: For the whole transfer, `ata_da` equals the requested address. A task-file access (`req_ctl_blk`=0) drives `ata_cs1_n`=1 and `ata_cs0_n`=0. A control-block access (`req_ctl_blk`=1) drives `ata_cs1_n`=0 and `ata_cs0_n`=1.
- R3: Before any strobe falls, chip selects and address are presented with both strobes high for `cfg_setup` cycles.
- R4: Only the strobe for the operation goes low: `ata_dior_n` for reads, `ata_diow_n` for writes. With IORDY checking off, or with IORDY high, the strobe stays low for the active count of the selected set: `cfg_act16` when `req_data_port`=1, otherwise `cfg_act8`.
- R5: With `cfg_iordy_en`=1, when the active count has run out the strobe stays low while the synchronized IORDY is low. The strobe is never low for more than `IORDY_LIMIT` cycles in total, counted from its fall, unless the programmed active count is itself larger. IORDY passes through a two-flop synchronizer, so a rise on the pin ends the phase two cycles later. With `cfg_iordy_en`=0, IORDY has no effect.
- R6: After the strobe rises, chip selects stay asserted for a recovery of (cycle count minus actual active cycles) when that difference exceeds the selected recovery count, and for the recovery count otherwise.
- R7: For a read, `rdata` holds the value on `ata_dd_in` at the rising edge of `ata_dior_n`. `done` pulses high for exactly one cycle when the transfer ends, one cycle after the chip selects leave the recovery phase.
- R8: For a write, `ata_dd_oe` is high and `ata_dd_out` equals the write word while `ata_diow_n` is low. The enable then stays high for 3 cycles after the strobe rises in PIO mode 0, 2 cycles in modes 1 and 2, and 1 cycle in modes 3 and 4. For a read, the enable stays low.
- R9: A request is taken only while `req_ready` is high. A request raised during a transfer is ignored and starts no further transfer.
- R10: A configured count of zero behaves as a count of one for setup, active and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_port | input | 1 | 1 = 16-bit data port timing, 0 = 8-bit register timing |
| req_ctl_blk | input | 1 | 1 = control block chip select, 0 = task-file chip select |
| req_addr | input | ADDR_W | Device register address |
| req_wdata | input | DATA_W | Write word |
| cfg_setup | input | CNT_W | Setup cycles |
| cfg_act8 | input | CNT_W | Register active cycles |
| cfg_cyc8 | input | CNT_W | Register total cycle length |
| cfg_rec8 | input | CNT_W | Register minimum recovery |
| cfg_act16 | input | CNT_W | Data active cycles |
| cfg_cyc16 | input | CNT_W | Data total cycle length |
| cfg_rec16 | input | CNT_W | Data minimum recovery |
| cfg_pio_mode | input | 3 | PIO mode 0..4 for write hold |
| cfg_iordy_en | input | 1 | Enable IORDY stretching |
| iordy_in | input | 1 | Device IORDY pin (asynchronous) |
| ata_dd_in | input | DATA_W | Device data bus input |
| req_ready | output | 1 | Idle and able to take a request |
| ata_cs0_n | output | 1 | Task-file chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | ADDR_W | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | DATA_W | Device data bus output |
| ata_dd_oe | output | 1 | Data bus output enable |
| rdata | output | DATA_W | Captured read word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the bus-level rules on every cycle. The two strobes are never low together, and exactly one chip select is asserted while a strobe is low. A strobe falls only after a cycle with chip selects asserted and both strobes high. The write strobe never drops without the bus enabled. `done` never lasts two cycles, the idle outputs are correct whenever `req_ready` is high, and a counter bounds the strobe-low window. Only the bench scenarios show the exact phase lengths per timing set, the recovery choice between cycle-minus-active and minimum recovery, the timing of IORDY release through the synchronizer, the mode-dependent write hold, captured read values, and that a request made while busy is dropped.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } pio_state_e;

  // write data hold after strobe release, in clocks, per PIO mode
  function automatic logic [1:0] hold_for_mode(input logic [2:0] mode);
    if (mode == 3'd0)      return 2'd3;
    else if (mode < 3'd3)  return 2'd2;
    else                   return 2'd1;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel import pio_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             data_port,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] act8,
  input  logic [CNT_W-1:0] cyc8,
  input  logic [CNT_W-1:0] rec8,
  input  logic [CNT_W-1:0] act16,
  input  logic [CNT_W-1:0] cyc16,
  input  logic [CNT_W-1:0] rec16,
  input  logic [CNT_W-1:0] act_taken,
  input  logic [2:0]       pio_mode,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] act_len,
  output logic [CNT_W-1:0] rec_len,
  output logic [1:0]       hold_len
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cyc_sel, rec_min, span;

  always_comb begin
    setup_len = (setup == '0) ? ONE : setup;
    if (data_port) begin
      act_len = (act16 == '0) ? ONE : act16;
      cyc_sel = cyc16;
      rec_min = (rec16 == '0) ? ONE : rec16;
    end else begin
      act_len = (act8 == '0) ? ONE : act8;
      cyc_sel = cyc8;
      rec_min = (rec8 == '0) ? ONE : rec8;
    end
    span = cyc_sel - act_taken;
    if (cyc_sel > act_taken && span > rec_min) rec_len = span;
    else                                        rec_len = rec_min;
    hold_len = hold_for_mode(pio_mode);
  end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq import pio_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int CNT_W       = 8,
  parameter int IORDY_LIMIT = 129
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_data_port,
  input  logic              req_ctl_blk,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_act8,
  input  logic [CNT_W-1:0]  cfg_cyc8,
  input  logic [CNT_W-1:0]  cfg_rec8,
  input  logic [CNT_W-1:0]  cfg_act16,
  input  logic [CNT_W-1:0]  cfg_cyc16,
  input  logic [CNT_W-1:0]  cfg_rec16,
  input  logic [2:0]        cfg_pio_mode,
  input  logic              cfg_iordy_en,
  input  logic              iordy_in,
  input  logic [DATA_W-1:0] ata_dd_in,
  output logic              req_ready,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [ADDR_W-1:0] ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(IORDY_LIMIT);

  pio_state_e       state;
  logic [CNT_W-1:0] cnt, act_taken;
  logic [CNT_W-1:0] setup_len, act_len, rec_len;
  logic [1:0]       hold_len, hold_cnt;
  logic             wr_q, dport_q, iordy_s, act_exit;

  pio_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (iordy_in),
    .d_out (iordy_s)
  );

  pio_timing_sel #(.CNT_W(CNT_W)) u_tsel (
    .data_port (dport_q),
    .setup     (cfg_setup),
    .act8      (cfg_act8),
    .cyc8      (cfg_cyc8),
    .rec8      (cfg_rec8),
    .act16     (cfg_act16),
    .cyc16     (cfg_cyc16),
    .rec16     (cfg_rec16),
    .act_taken (act_taken),
    .pio_mode  (cfg_pio_mode),
    .setup_len (setup_len),
    .act_len   (act_len),
    .rec_len   (rec_len),
    .hold_len  (hold_len)
  );

  assign req_ready = (state == ST_IDLE) && (hold_cnt == 2'd0);
  assign act_exit  = (state == ST_ACTIVE) && (cnt == '0) &&
                     !(cfg_iordy_en && !iordy_s && act_taken < LIMIT_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      act_taken  <= '0;
      wr_q       <= 1'b0;
      dport_q    <= 1'b0;
      ata_cs0_n  <= 1'b1;
      ata_cs1_n  <= 1'b1;
      ata_da     <= '0;
      ata_dior_n <= 1'b1;
      ata_diow_n <= 1'b1;
      ata_dd_out <= '0;
      rdata      <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            state      <= ST_SETUP;
            wr_q       <= req_write;
            dport_q    <= req_data_port;
            ata_da     <= req_addr;
            ata_cs0_n  <= req_ctl_blk;
            ata_cs1_n  <= !req_ctl_blk;
            ata_dd_out <= req_wdata;
            cnt        <= setup_len - 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state      <= ST_ACTIVE;
            ata_dior_n <= wr_q;
            ata_diow_n <= !wr_q;
            cnt        <= act_len - 1'b1;
            act_taken  <= CNT_W'(1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (act_exit) begin
            state      <= ST_RECOVER;
            ata_dior_n <= 1'b1;
            ata_diow_n <= 1'b1;
            if (!wr_q) rdata <= ata_dd_in;
            cnt        <= rec_len - 1'b1;
          end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            act_taken <= act_taken + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            ata_cs0_n <= 1'b1;
            ata_cs1_n <= 1'b1;
            done      <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // data bus enable and post-write hold
  always_ff @(posedge clk) begin
    if (rst) begin
      ata_dd_oe <= 1'b0;
      hold_cnt  <= 2'd0;
    end else if (state == ST_SETUP && cnt == '0 && wr_q) begin
      ata_dd_oe <= 1'b1;
    end else if (act_exit && wr_q) begin
      hold_cnt <= hold_len;
    end else if (hold_cnt != 2'd0) begin
      hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == 2'd1) ata_dd_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk #(
  parameter int CNT_W       = 8,
  parameter int IORDY_LIMIT = 129
) (
  input logic             clk,
  input logic             rst,
  input logic             ata_cs0_n,
  input logic             ata_cs1_n,
  input logic             ata_dior_n,
  input logic             ata_diow_n,
  input logic             ata_dd_oe,
  input logic             done,
  input logic             req_ready,
  input logic [CNT_W-1:0] cfg_act8,
  input logic [CNT_W-1:0] cfg_act16
);
  logic        strobe_hi, cs_on;
  logic [15:0] low_cnt;
  int          bound;

  assign strobe_hi = ata_dior_n && ata_diow_n;
  assign cs_on     = !ata_cs0_n || !ata_cs1_n;

  always_comb begin
    bound = IORDY_LIMIT;
    if (int'(cfg_act8) > bound)  bound = int'(cfg_act8);
    if (int'(cfg_act16) > bound) bound = int'(cfg_act16);
  end

  always_ff @(posedge clk) begin
    if (rst || strobe_hi) low_cnt <= '0;
    else                  low_cnt <= low_cnt + 1'b1;
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!ata_dior_n && !ata_diow_n));

  assert_one_cs_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_hi |-> $countones({ata_cs0_n, ata_cs1_n}) == 1);

  assert_setup_first_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_hi) |-> $past(cs_on && strobe_hi));

  assert_write_driven_R8: assert property (@(posedge clk) disable iff (rst)
    !ata_diow_n |-> ata_dd_oe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (strobe_hi && !cs_on && !ata_dd_oe));

  assert_stretch_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(low_cnt) <= bound);
endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(.CNT_W(CNT_W), .IORDY_LIMIT(IORDY_LIMIT)) chk_i (.*);

// File: tb/pio_cycle_seq_tb.sv
module pio_cycle_seq_tb_top;
  localparam int DW = 16, AW = 3, CW = 8, LIM = 129;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_data_port = 0, req_ctl_blk = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ata_dd_in = '0;
  logic [CW-1:0] cfg_setup, cfg_act8, cfg_cyc8, cfg_rec8, cfg_act16, cfg_cyc16, cfg_rec16;
  logic [2:0] cfg_pio_mode = 3'd0;
  logic cfg_iordy_en = 0, iordy_in = 1;
  logic req_ready, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, done;
  logic [AW-1:0] ata_da;
  logic [DW-1:0] ata_dd_out, rdata;

  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  pio_cycle_seq #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .IORDY_LIMIT(LIM)) dut_i (.*);

  // {write, data_port, ctl_blk, addr[2:0], data[15:0]}
  localparam logic [21:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 3'd7, 16'h0050},
    {1'b1, 1'b0, 1'b0, 3'd1, 16'h00A5},
    {1'b0, 1'b0, 1'b1, 3'd6, 16'h00C3},
    {1'b1, 1'b1, 1'b0, 3'd0, 16'hBEEF},
    {1'b0, 1'b1, 1'b0, 3'd0, 16'h1234},
    {1'b1, 1'b0, 1'b1, 3'd6, 16'h0004}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int hold_exp(input int m);
    return (m == 0) ? 3 : (m < 3) ? 2 : 1;
  endfunction

  task automatic wait_ready();
    for (int i = 0; i < 20 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic run_cycle(input bit wr, input bit dp, input bit ctl, input logic [2:0] ad,
                           input logic [15:0] dat, input bit iordy0, input int raise_at);
    int n_set = 0, n_act = 0, n_rec = 0, n_hold = 0, n_done = 0;
    bit seen = 0, enc_ok = 1, strb_ok = 1, wdat_ok = 1, rd_oe = 0;
    int e_act, e_rec, cyc, act_cfg, rec_cfg;
    logic [15:0] got_rd = '0;
    wait_ready();
    iordy_in = iordy0;
    ata_dd_in = dat;
    req_write = wr; req_data_port = dp; req_ctl_blk = ctl; req_addr = ad; req_wdata = dat;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 400; i++) begin
      if (!ata_dior_n || !ata_diow_n) begin
        n_act++; seen = 1;
        if (ata_da != ad || ata_cs1_n != !ctl || ata_cs0_n != ctl) enc_ok = 0;
        if (wr ? (ata_diow_n || !ata_dior_n) : (ata_dior_n || !ata_diow_n)) strb_ok = 0;
        if (wr && (!ata_dd_oe || ata_dd_out != dat)) wdat_ok = 0;
        if (raise_at != 0 && n_act == raise_at) iordy_in = 1;
      end else if (seen && (!ata_cs0_n || !ata_cs1_n)) n_rec++;
      else if (!seen && (!ata_cs0_n || !ata_cs1_n)) n_set++;
      if (seen && ata_dior_n && ata_diow_n && ata_dd_oe) n_hold++;
      if (!wr && ata_dd_oe) rd_oe = 1;
      if (done) begin n_done++; got_rd = rdata; break; end
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (ata_dd_oe) n_hold++;
      if (done) n_done++;
    end
    act_cfg = dp ? int'(cfg_act16) : int'(cfg_act8);
    rec_cfg = dp ? int'(cfg_rec16) : int'(cfg_rec8);
    cyc     = dp ? int'(cfg_cyc16) : int'(cfg_cyc8);
    e_act = eff(act_cfg);
    if (cfg_iordy_en && !iordy0) begin
      int rel = (raise_at != 0) ? raise_at + 2 : LIM;
      if (rel > LIM) rel = LIM;
      if (rel > e_act) e_act = rel;
    end
    e_rec = (cyc > n_act && cyc - n_act > eff(rec_cfg)) ? cyc - n_act : eff(rec_cfg);
    chk(n_set == eff(int'(cfg_setup)), "R3 setup length", n_set, eff(int'(cfg_setup)));
    chk(enc_ok, "R2 cs/address encoding", enc_ok, 1);
    chk(strb_ok, "R4 strobe choice", strb_ok, 1);
    chk(n_act == e_act, "R4/R5 active length", n_act, e_act);
    chk(n_rec == e_rec, "R6 recovery length", n_rec, e_rec);
    chk(n_done == 1, "R7 single done pulse", n_done, 1);
    if (wr) begin
      chk(wdat_ok, "R8 write data driven", wdat_ok, 1);
      chk(n_hold == hold_exp(int'(cfg_pio_mode)), "R8 write hold", n_hold, hold_exp(int'(cfg_pio_mode)));
    end else begin
      chk(got_rd == dat, "R7 read data", int'(got_rd), int'(dat));
      chk(!rd_oe, "R8 no drive on read", rd_oe, 0);
    end
    iordy_in = 1;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    cfg_setup = 2; cfg_act8 = 5; cfg_cyc8 = 20; cfg_rec8 = 3;
    cfg_act16 = 6; cfg_cyc16 = 10; cfg_rec16 = 7;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_dd_oe && !done && req_ready,
        "R1 idle after reset", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, req_ready}, 6'b111101);

    // table-driven main function
    for (int v = 0; v < 6; v++)
      run_cycle(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18:16], VEC[v][15:0], 1'b1, 0);

    // R10 zero counts act as one
    cfg_setup = 0; cfg_act8 = 0; cfg_cyc8 = 0; cfg_rec8 = 0;
    run_cycle(1'b0, 1'b0, 1'b0, 3'd2, 16'h0011, 1'b1, 0);
    cfg_pio_mode = 3'd3;
    run_cycle(1'b1, 1'b0, 1'b0, 3'd3, 16'h0022, 1'b1, 0);   // R8 mode 3 hold
    cfg_pio_mode = 3'd1;
    cfg_setup = 2; cfg_act8 = 5; cfg_cyc8 = 20; cfg_rec8 = 3;
    run_cycle(1'b1, 1'b1, 1'b0, 3'd0, 16'h5A5A, 1'b1, 0);   // R8 mode 1 hold

    // R5 IORDY behaviour
    cfg_iordy_en = 1;
    run_cycle(1'b0, 1'b1, 1'b0, 3'd0, 16'h0F0F, 1'b1, 0);   // ready high: no stretch
    run_cycle(1'b0, 1'b1, 1'b0, 3'd0, 16'h3C3C, 1'b0, 10);  // released mid-phase
    run_cycle(1'b1, 1'b1, 1'b0, 3'd0, 16'hA0A0, 1'b0, 0);   // never ready: timeout
    cfg_iordy_en = 0;
    run_cycle(1'b0, 1'b1, 1'b0, 3'd0, 16'h7777, 1'b0, 0);   // disabled: pin ignored

    // R9 request during a transfer is dropped
    begin
      int extra = 0;
      wait_ready();
      req_write = 1; req_data_port = 0; req_ctl_blk = 0; req_addr = 3'd4; req_wdata = 16'h0099;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      repeat (4) @(negedge clk);
      req_ctl_blk = 1; req_addr = 3'd6; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      for (int i = 0; i < 100 && !done; i++) @(negedge clk);
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (!ata_cs0_n || !ata_cs1_n || done) extra++;
      end
      chk(extra == 0, "R9 busy request ignored", extra, 0);
      chk(req_ready, "R1 ready after hold", req_ready, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule